// File: doc/BRIEF.md
# SPI Command Queue Front End

This block sits between a register port and the serial frame engine of an SPI master. Software pushes 32-bit command words into a small transmit queue. Each word carries the data to send and its own per-frame controls: chip-select hold, attribute set, one-hot chip select, a counter reset and a halt marker. The block issues the words one at a time to the frame engine. It keeps at most one frame in flight, collects each received 16-bit frame into a receive queue and counts completed frames.

A status register holds four sticky flags: frame done, queue halted, transmit overflow and receive underflow. Each flag is cleared by writing 1 to its bit. An enable register with the same bit positions gates these flags onto a single interrupt line. Once a frame tagged as end of queue completes, issuing stops until software clears the halt flag. This lets software fill the queue ahead and take one interrupt per batch.

Top module: `spi_cmd_queue`

## Requirements
- R1: After synchronous reset, every register reads 0, both queues are empty, `fe_valid` is 0 and `irq` is 0.
- R2: A write to address 3 appends `wr_data` to the transmit queue, which holds up to DEPTH (4) words and issues them in arrival order.
- R3: A write to address 3 while the transmit queue holds DEPTH words leaves the queue unchanged and sets the transmit-overflow flag, status bit 27.
- R4: While the master bit (control bit 31) is 1, the halt flag is 0, the transmit queue is not empty and the receive queue has space, the block raises `fe_valid` with the oldest word on `fe_cmd`. It holds both stable until `fe_ready`, then issues nothing more until `fe_done`.
- R5: `fe_done` for the frame in flight appends `fe_rx` to the receive queue and sets the frame-done flag, status bit 31.
- R6: When the frame whose command has bit 27 set completes, the halt flag (status bit 28) is set and no further word is issued. Writing 0 to bit 28 changes nothing; writing 1 clears the flag and issuing resumes if words remain.
- R7: Address 5 returns the completed-frame counter in bits 16 upward. The counter is CNT_W bits (16 by default) and wraps from all ones to 0. A completed frame whose command has bit 26 set leaves the counter at 1.
- R8: A read of address 4 returns the oldest received frame in bits 15:0 and removes it. On an empty receive queue it returns 0, changes nothing and sets the receive-underflow flag, status bit 26.
- R9: A write to address 0 stores the master bit from bit 31. Bit 11 empties the transmit queue and bit 10 empties the receive queue.
- R10: A write to address 1 clears each status flag whose bit is 1. An event that sets a flag in the same cycle wins over its clear.
- R11: Address 2 holds interrupt enables at bits 31, 28, 27 and 26. `irq` is high exactly when some flag and its enable are both 1, updated on the same edge as the flags.
- R12: While the receive queue is full, no word is issued, even if the transmit queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1 status, 2 enable, 3 push) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address (0 control, 1 status, 2 enable, 4 pop, 5 counter) |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| fe_valid | output | 1 | Command offered to the frame engine |
| fe_cmd | output | 32 | Command word offered to the frame engine |
| fe_ready | input | 1 | Frame engine accepts the command |
| fe_done | input | 1 | Frame engine finished the frame in flight |
| fe_rx | input | 16 | Data received in the finished frame |
| irq | output | 1 | Interrupt request |

## Verification
A behavioural model built on queues is compared with the design on every cycle while the queue is driven in several ways. One run fills the queue with the master bit off, so that overflow and issuing stay apart. Another lets the receive queue fill, to show that a full receive side stalls transmit. A halt-marked word in the middle of a batch separates halting from merely running dry. A slow engine that stalls `fe_ready` and delays `fe_done` shows that the offered command stays stable and that only one frame is in flight. A long run of single frames on a narrow counter shows the wrap. Flushes and underflow reads show that the queues really empty and that an empty pop leaves state unchanged.

// File: rtl/spi_cq_pkg.sv
package spi_cq_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PUSH = 3'd3;
  localparam logic [ADDR_W-1:0] A_POP  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd5;

  // status and enable bit positions
  localparam int B_TC  = 31;
  localparam int B_EOQ = 28;
  localparam int B_OVF = 27;
  localparam int B_UDF = 26;

  // command word fields decoded here (others go to the frame engine)
  localparam int C_EOQ = 27;
  localparam int C_CLR = 26;

  // control bits
  localparam int K_MASTER = 31;
  localparam int K_FTX    = 11;
  localparam int K_FRX    = 10;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} sq_state_e;
endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_p, rd_p;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_p];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_p] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wr_p <= nxt(wr_p);
      if (pop_ok)  rd_p <= nxt(rd_p);
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  assert_full_push_R3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/cq_sequencer.sv
module cq_sequencer
  import spi_cq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [31:0]      head,
  input  logic             fe_ready,
  input  logic             fe_done,
  output logic             take,
  output logic             fe_valid,
  output logic [31:0]      fe_cmd,
  output logic             done_ev,
  output logic             done_eoq,
  output logic [CNT_W-1:0] cnt
);
  sq_state_e st;

  assign take     = (st == SQ_IDLE) && go;
  assign done_ev  = (st == SQ_WAIT) && fe_done;
  assign done_eoq = done_ev && fe_cmd[C_EOQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      fe_valid <= 1'b0;
      fe_cmd   <= '0;
      cnt      <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (go) begin
          st       <= SQ_REQ;
          fe_valid <= 1'b1;
          fe_cmd   <= head;
        end
        SQ_REQ: if (fe_ready) begin
          st       <= SQ_WAIT;
          fe_valid <= 1'b0;
        end
        SQ_WAIT: if (fe_done) begin
          st  <= SQ_IDLE;
          cnt <= fe_cmd[C_CLR] ? CNT_W'(1) : cnt + 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_hold_offer_R4: assert property (@(posedge clk) disable iff (rst)
    (fe_valid && !fe_ready) |=> (fe_valid && $stable(fe_cmd)));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
    (done_ev && !fe_cmd[C_CLR]) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/spi_cmd_queue.sv
module spi_cmd_queue
  import spi_cq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        fe_valid,
  output logic [31:0] fe_cmd,
  input  logic        fe_ready,
  input  logic        fe_done,
  input  logic [15:0] fe_rx,
  output logic        irq
);
  localparam int RX_W = 16;

  logic master_q, tc_q, eoq_q, ovf_q, udf_q;
  logic ie_tc, ie_eoq, ie_ovf, ie_udf;
  logic tc_d, eoq_d, ovf_d, udf_d;
  logic ie_tc_d, ie_eoq_d, ie_ovf_d, ie_udf_d;

  logic wr_ctrl, wr_stat, wr_ien, push_req, pop_req;
  logic [31:0] clr;
  logic [31:0] head_tx;
  logic [RX_W-1:0] head_rx;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic go, take, done_ev, done_eoq;
  logic [CNT_W-1:0] cnt;
  logic [31:0] stat_word, ien_word, cnt_word;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_stat  = wr_en && (wr_addr == A_STAT);
  assign wr_ien   = wr_en && (wr_addr == A_IEN);
  assign push_req = wr_en && (wr_addr == A_PUSH);
  assign pop_req  = rd_en && (rd_addr == A_POP);
  assign clr      = wr_stat ? wr_data : '0;

  cq_fifo #(.W(32), .DEPTH(DEPTH)) tx_q (
    .clk(clk), .rst(rst), .flush(wr_ctrl && wr_data[K_FTX]),
    .push(push_req), .push_data(wr_data), .pop(take),
    .head(head_tx), .full(tx_full), .empty(tx_empty));

  cq_fifo #(.W(RX_W), .DEPTH(DEPTH)) rx_q (
    .clk(clk), .rst(rst), .flush(wr_ctrl && wr_data[K_FRX]),
    .push(done_ev), .push_data(fe_rx), .pop(pop_req),
    .head(head_rx), .full(rx_full), .empty(rx_empty));

  assign go = master_q && !eoq_q && !tx_empty && !rx_full;

  cq_sequencer #(.CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst(rst), .go(go), .head(head_tx),
    .fe_ready(fe_ready), .fe_done(fe_done), .take(take),
    .fe_valid(fe_valid), .fe_cmd(fe_cmd), .done_ev(done_ev),
    .done_eoq(done_eoq), .cnt(cnt));

  always_comb begin
    tc_d  = done_ev  | (tc_q  & ~clr[B_TC]);
    eoq_d = done_eoq | (eoq_q & ~clr[B_EOQ]);
    ovf_d = (push_req && tx_full)  | (ovf_q & ~clr[B_OVF]);
    udf_d = (pop_req  && rx_empty) | (udf_q & ~clr[B_UDF]);
    ie_tc_d  = wr_ien ? wr_data[B_TC]  : ie_tc;
    ie_eoq_d = wr_ien ? wr_data[B_EOQ] : ie_eoq;
    ie_ovf_d = wr_ien ? wr_data[B_OVF] : ie_ovf;
    ie_udf_d = wr_ien ? wr_data[B_UDF] : ie_udf;

    stat_word = '0;
    stat_word[B_TC]  = tc_q;
    stat_word[B_EOQ] = eoq_q;
    stat_word[B_OVF] = ovf_q;
    stat_word[B_UDF] = udf_q;
    ien_word = '0;
    ien_word[B_TC]  = ie_tc;
    ien_word[B_EOQ] = ie_eoq;
    ien_word[B_OVF] = ie_ovf;
    ien_word[B_UDF] = ie_udf;
    cnt_word = '0;
    cnt_word[16 +: CNT_W] = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      master_q <= 1'b0;
      {tc_q, eoq_q, ovf_q, udf_q} <= '0;
      {ie_tc, ie_eoq, ie_ovf, ie_udf} <= '0;
      irq <= 1'b0;
    end else begin
      if (wr_ctrl) master_q <= wr_data[K_MASTER];
      {tc_q, eoq_q, ovf_q, udf_q} <= {tc_d, eoq_d, ovf_d, udf_d};
      {ie_tc, ie_eoq, ie_ovf, ie_udf} <= {ie_tc_d, ie_eoq_d, ie_ovf_d, ie_udf_d};
      irq <= (tc_d & ie_tc_d) | (eoq_d & ie_eoq_d) |
             (ovf_d & ie_ovf_d) | (udf_d & ie_udf_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        A_CTRL:  rd_data <= {master_q, 31'b0};
        A_STAT:  rd_data <= stat_word;
        A_IEN:   rd_data <= ien_word;
        A_POP:   rd_data <= rx_empty ? '0 : {16'b0, head_rx};
        A_CNT:   rd_data <= cnt_word;
        default: rd_data <= '0;
      endcase
    end
  end

  assert_eoq_halt_R6: assert property (@(posedge clk) disable iff (rst)
    (eoq_q && !fe_valid) |=> !fe_valid);

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (pop_req && rx_empty) |=> (rd_data == 32'b0 && udf_q));

  assert_done_flag_R5: assert property (@(posedge clk) disable iff (rst)
    done_ev |=> tc_q);

  assert_rx_full_block_R12: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !fe_valid && !pop_req && !(wr_ctrl && wr_data[K_FRX])) |=> !fe_valid);
endmodule

// File: tb/spi_cmd_queue_tb.sv
module spi_cmd_queue_tb_top;
  localparam int DEPTH = 4;
  localparam int CNT_W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, fe_cmd;
  logic        fe_valid, irq;
  logic        fe_ready = 1'b0, fe_done = 1'b0;
  logic [15:0] fe_rx = '0;

  always #2.5 clk = ~clk;

  spi_cmd_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .fe_valid(fe_valid),
    .fe_cmd(fe_cmd), .fe_ready(fe_ready), .fe_done(fe_done), .fe_rx(fe_rx),
    .irq(irq));

  int checks = 0, errors = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- frame engine stand-in ----------------
  int  eng_lat = 0, eng_stall = 0, stall_left = 0, eng_cd = 0;
  bit  eng_pend = 0;
  logic [15:0] eng_data;

  always @(negedge clk) begin
    fe_done <= 1'b0;
    if (!rst) begin
      if (eng_pend) begin
        if (eng_cd == 0) begin
          fe_done  <= 1'b1;
          fe_rx    <= eng_data;
          eng_pend = 0;
        end else eng_cd--;
      end
      if (fe_valid && stall_left > 0) begin
        fe_ready <= 1'b0;
        stall_left--;
      end else if (fe_valid) begin
        fe_ready   <= 1'b1;
        eng_pend   = 1;
        eng_cd     = eng_lat;
        eng_data   = fe_cmd[15:0] ^ 16'h5A3C;
        stall_left = eng_stall;
      end else fe_ready <= 1'b0;
    end
  end

  // ---------------- reference model ----------------
  logic [31:0] txq[$];
  logic [15:0] rxq[$];
  int   m_st = 0, m_cnt = 0;
  bit   m_valid = 0, m_master = 0, m_tc = 0, m_eoq = 0, m_ovf = 0, m_udf = 0, m_irq = 0;
  bit   m_ie_tc = 0, m_ie_eoq = 0, m_ie_ovf = 0, m_ie_udf = 0;
  logic [31:0] m_cmd = '0, m_rd_exp = '0;
  bit   m_rd_chk = 0;
  logic [2:0] m_rd_addr = '0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      txq.delete(); rxq.delete();
      m_st = 0; m_cnt = 0; m_valid = 0; m_master = 0;
      {m_tc, m_eoq, m_ovf, m_udf, m_irq} = '0;
      {m_ie_tc, m_ie_eoq, m_ie_ovf, m_ie_udf} = '0;
      m_rd_chk = 0;
    end else begin
      int  txs, rxs;
      bit  issue, hs, dn, s_tc, s_eoq, s_ovf, s_udf;
      logic [31:0] c, st;
      logic [2:0] wa;
      txs = txq.size(); rxs = rxq.size();
      issue = (m_st == 0) && m_master && !m_eoq && txs > 0 && rxs < DEPTH;
      hs = (m_st == 1) && fe_ready;
      dn = (m_st == 2) && fe_done;
      wa = wr_en ? wr_addr : 3'd7;
      {s_tc, s_eoq, s_ovf, s_udf} = '0;
      st = '0; st[31] = m_tc; st[28] = m_eoq; st[27] = m_ovf; st[26] = m_udf;
      m_rd_chk = rd_en; m_rd_addr = rd_addr;
      if (rd_en) begin
        case (rd_addr)
          3'd0: m_rd_exp = {m_master, 31'b0};
          3'd1: m_rd_exp = st;
          3'd2: begin m_rd_exp = '0; m_rd_exp[31] = m_ie_tc; m_rd_exp[28] = m_ie_eoq;
                  m_rd_exp[27] = m_ie_ovf; m_rd_exp[26] = m_ie_udf; end
          3'd4: if (rxs == 0) begin m_rd_exp = '0; s_udf = 1; end
                else m_rd_exp = {16'b0, rxq.pop_front()};
          3'd5: m_rd_exp = 32'(m_cnt) << 16;
          default: m_rd_exp = '0;
        endcase
      end
      if (issue) begin
        m_cmd = txq.pop_front(); m_st = 1; m_valid = 1;
      end else if (hs) begin
        m_st = 2; m_valid = 0;
      end else if (dn) begin
        m_st = 0; rxq.push_back(fe_rx); s_tc = 1; s_eoq = m_cmd[27];
        m_cnt = m_cmd[26] ? 1 : (m_cnt + 1) % (1 << CNT_W);
      end
      if (wa == 3'd3) begin
        if (txs == DEPTH) s_ovf = 1; else txq.push_back(wr_data);
      end
      if (wa == 3'd0) begin
        m_master = wr_data[31];
        if (wr_data[11]) txq.delete();
        if (wr_data[10]) rxq.delete();
      end
      c = (wa == 3'd1) ? wr_data : '0;
      m_tc  = s_tc  | (m_tc  & !c[31]);
      m_eoq = s_eoq | (m_eoq & !c[28]);
      m_ovf = s_ovf | (m_ovf & !c[27]);
      m_udf = s_udf | (m_udf & !c[26]);
      if (wa == 3'd2) begin
        m_ie_tc = wr_data[31]; m_ie_eoq = wr_data[28];
        m_ie_ovf = wr_data[27]; m_ie_udf = wr_data[26];
      end
      m_irq = (m_tc & m_ie_tc) | (m_eoq & m_ie_eoq) | (m_ovf & m_ie_ovf) | (m_udf & m_ie_udf);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(fe_valid == m_valid, "R4 offer valid", 32'(fe_valid), 32'(m_valid));
      if (m_valid) check(fe_cmd == m_cmd, "R2 offered word", fe_cmd, m_cmd);
      check(irq == m_irq, "R11 irq", 32'(irq), 32'(m_irq));
      if (m_rd_chk) begin
        case (m_rd_addr)
          3'd4:    check(rd_data == m_rd_exp, "R8 pop data", rd_data, m_rd_exp);
          3'd5:    check(rd_data == m_rd_exp, "R7 counter", rd_data, m_rd_exp);
          3'd1:    check(rd_data == m_rd_exp, "R10 status", rd_data, m_rd_exp);
          default: check(rd_data == m_rd_exp, "R9 register", rd_data, m_rd_exp);
        endcase
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0; v = rd_data;
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(v == e, tag, v, e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] rxv(input logic [31:0] w);
    return {16'b0, w[15:0] ^ 16'h5A3C};
  endfunction

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  localparam logic [31:0] W1 = 32'h8001_1111, W2 = 32'h8002_2222, W3 = 32'h1004_3333,
                          W4 = 32'h0008_4444, W5 = 32'h0010_5555, W6 = 32'h8020_6666;

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check(fe_valid == 1'b0 && irq == 1'b0, "R1 outputs after reset", {fe_valid, irq}, 0);
    rd_expect(3'd0, 32'h0, "R1 control");
    rd_expect(3'd1, 32'h0, "R1 status");
    rd_expect(3'd2, 32'h0, "R1 enable");
    rd_expect(3'd5, 32'h0, "R1 counter");

    // R3 overflow with master off
    wr(3'd3, W1); wr(3'd3, W2); wr(3'd3, W3); wr(3'd3, W4);
    wr(3'd3, W5);
    idle(2);
    check(fe_valid == 1'b0, "R4 no offer without master", 32'(fe_valid), 0);
    rd_expect(3'd1, 32'h0800_0000, "R3 overflow flag");
    wr(3'd2, 32'h0800_0000);
    check(irq == 1'b1, "R11 irq on enabled overflow", 32'(irq), 1);
    wr(3'd1, 32'h0800_0000);
    check(irq == 1'b0, "R10 w1c drops irq", 32'(irq), 0);
    wr(3'd2, 32'h9C00_0000);

    // R2/R5/R12: run, receive queue fills, a fifth word waits
    wr(3'd0, 32'h8000_0000);
    idle(20);
    wr(3'd3, W6);
    idle(10);
    check(fe_valid == 1'b0, "R12 receive full blocks issue", 32'(fe_valid), 0);
    rd_expect(3'd1, 32'h8000_0000, "R5 done flag");
    rd_expect(3'd5, 32'h0004_0000, "R7 four frames");
    rd_expect(3'd4, rxv(W1), "R2 order 1");
    rd_expect(3'd4, rxv(W2), "R2 order 2");
    rd_expect(3'd4, rxv(W3), "R2 order 3");
    rd_expect(3'd4, rxv(W4), "R2 order 4");
    idle(6);
    rd_expect(3'd4, rxv(W6), "R12 resumes after pop");

    // R6 end of queue halts, write 0 ignored, write 1 resumes
    wr(3'd1, 32'h8000_0000);
    wr(3'd3, W1 | 32'h0800_0000); wr(3'd3, W2); wr(3'd3, W3);
    idle(15);
    rd_expect(3'd1, 32'h9000_0000, "R6 halt flag");
    rd_expect(3'd5, 32'h0006_0000, "R6 only halt frame ran");
    wr(3'd1, 32'h0);
    idle(8);
    rd_expect(3'd1, 32'h9000_0000, "R6 write 0 no effect");
    rd_expect(3'd5, 32'h0006_0000, "R6 still halted");
    wr(3'd1, 32'h1000_0000);
    idle(12);
    rd_expect(3'd1, 32'h8000_0000, "R6 cleared");
    rd_expect(3'd4, rxv(W1 | 32'h0800_0000), "R6 data a");
    rd_expect(3'd4, rxv(W2), "R6 data b");
    rd_expect(3'd4, rxv(W3), "R6 data c");

    // R7 counter clear bit
    wr(3'd3, W4 | 32'h0400_0000);
    idle(8);
    rd_expect(3'd5, 32'h0001_0000, "R7 clear gives 1");
    rd_expect(3'd4, rxv(W4 | 32'h0400_0000), "R8 pop");

    // R8 underflow
    rd_expect(3'd4, 32'h0, "R8 empty pop returns 0");
    rd_expect(3'd1, 32'h8400_0000, "R8 underflow flag");
    wr(3'd1, 32'hFFFF_FFFF);

    // R9 flush both queues
    wr(3'd3, W5); wr(3'd3, W6);
    idle(10);
    wr(3'd0, 32'h0);
    wr(3'd3, W1); wr(3'd3, W2);
    wr(3'd0, 32'h0000_0C00);
    rd_expect(3'd0, 32'h0, "R9 master off");
    rd_expect(3'd4, 32'h0, "R9 receive flushed");
    wr(3'd0, 32'h8000_0000);
    idle(8);
    rd_expect(3'd5, 32'h0003_0000, "R9 transmit flushed");
    wr(3'd1, 32'hFFFF_FFFF);

    // R4 slow engine
    eng_stall = 3; eng_lat = 2; stall_left = 3;
    wr(3'd3, W3); wr(3'd3, W4);
    idle(30);
    rd_expect(3'd4, rxv(W3), "R4 slow frame 1");
    rd_expect(3'd4, rxv(W4), "R4 slow frame 2");
    eng_stall = 0; eng_lat = 0; stall_left = 0;

    // R7 wrap on an 8-bit counter
    wr(3'd3, 32'h0400_0000);
    idle(5);
    rd_expect(3'd4, rxv(32'h0400_0000), "R7 wrap first");
    for (int i = 1; i < 260; i++) begin
      wr(3'd3, 32'(i));
      idle(5);
      rd_expect(3'd4, rxv(32'(i)), "R7 wrap data");
    end
    rd_expect(3'd5, 32'h0004_0000, "R7 wrapped count");

    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule